// File: doc/BRIEF.md
# LCD Pixel Word Unpacker

This block sits between a pixel word FIFO and the data pins of an LCD panel. It accepts 32-bit memory words through a valid/ready handshake. Each time the display timing generator asserts its pixel strobe, the block emits one pixel on the panel bus. Two memory layouts are understood. In the first, a word holds two packed 16-bit 5-6-5 pixels. In the second, a word holds one 24-bit pixel in its three low bytes and the top byte is ignored.

Every pixel is first widened to an internal 8-bit-per-channel colour by copying each channel's upper bits into its lower bits. It is then placed on a 16-, 18- or 24-bit panel bus, keeping the top bits of each channel. A configuration the block cannot serve raises an error flag and keeps the bus silent. A strobe that finds no word waiting sets a sticky underflow flag and drives zero.

Top module: `lcd_pixel_unpacker`

## Requirements
- R1: While reset is held and in the cycle after it, `pix_valid`, `pix_data`, `underflow` and `cfg_err` (for a legal configuration) are all 0. `word_ready` is 0 while `pix_strobe` is low.
- R2: With `cfg_word_fmt` = 0 (5-6-5), each word yields two pixels: bits [15:0] on the first strobe and bits [31:16] on the second. `word_ready` is high only during the strobe that sends the second half.
- R3: With `cfg_word_fmt` = 3 (24-bit), each word yields one pixel. `word_ready` is high on every accepted strobe, and bits [31:24] of the word have no effect on the output.
- R4: A 5-6-5 pixel holds red in [15:11], green in [10:5] and blue in [4:0]. A 24-bit pixel holds red in [23:16], green in [15:8] and blue in [7:0].
- R5: With `cfg_bus_width` = 3 (24-bit bus), `pix_data` = {R8,G8,B8}. A 5-6-5 channel of n bits becomes 8 bits by appending its top 8-n bits.
- R6: With `cfg_bus_width` = 2 (18-bit bus), `pix_data[17:0]` = {R6,G6,B6} and bits [23:18] are 0. The 6 bits are the top 6 bits of each channel after the widening of R5.
- R7: With `cfg_bus_width` = 0 (16-bit bus), `pix_data[15:0]` = {R5,G6,B5}, taken from the top bits of each widened channel, and bits [23:16] are 0.
- R8: `cfg_word_fmt` codes 1 and 2 and `cfg_bus_width` = 1 (8-bit bus) are unsupported. In those configurations `cfg_err` is 1, `word_ready` stays 0, and `pix_valid` and `pix_data` stay 0.
- R9: A strobe while `word_valid` is low (legal configuration) gives `pix_valid` = 0 and `pix_data` = 0 in the next cycle. It sets `underflow`, which stays 1 until reset, and it does not advance the half-word position.
- R10: A pixel strobed at a clock edge appears on `pix_data` with `pix_valid` = 1 right after that edge. Without a strobe, `pix_valid` is 0, `pix_data` is 0 and no word is consumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_word_fmt | input | 2 | Memory word layout: 0 = two 5-6-5 pixels, 3 = one 24-bit pixel |
| cfg_bus_width | input | 2 | Panel bus: 0 = 16-bit, 1 = 8-bit (rejected), 2 = 18-bit, 3 = 24-bit |
| word_valid | input | 1 | A FIFO word is present on `word_data` |
| word_data | input | 32 | FIFO word |
| word_ready | output | 1 | The word is consumed at this clock edge |
| pix_strobe | input | 1 | Timing generator requests one pixel |
| pix_valid | output | 1 | `pix_data` carries a pixel |
| pix_data | output | 24 | Panel pixel bus, right-aligned |
| cfg_err | output | 1 | Configuration is unsupported |
| underflow | output | 1 | Sticky: a pixel was requested with no word present |

## Verification
The assertions assume three things about the inputs. The word layout does not change while a packed word is half delivered. The bus width does not change between a strobe and the cycle that shows its pixel. The inputs are low while reset is held. The stimulus drives every input on the falling clock edge and applies reset before each scenario. It changes the configuration only in that reset window, or while no strobe is active. Word data is held steady for as long as `word_valid` is high and the word has not been consumed.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    localparam int CH_W   = 8;
    localparam int WORD_W = 32;
    localparam int BUS_W  = 3 * CH_W;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [1:0] {
        FMT_RGB565 = 2'd0,
        FMT_RSVD1  = 2'd1,
        FMT_RSVD2  = 2'd2,
        FMT_RGB888 = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        BUS_16 = 2'd0,
        BUS_8  = 2'd1,
        BUS_18 = 2'd2,
        BUS_24 = 2'd3
    } bus_e;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    // Which bytes of a FIFO word carry pixel data
    function automatic logic [LANES-1:0] lane_mask(fmt_e f);
        return (f == FMT_RGB565) ? 4'hF : 4'h7;
    endfunction

    // Widen 5-6-5 by copying the upper bits of each channel downward
    function automatic rgb_t widen_565(logic [15:0] p);
        rgb_t c;
        c.r = {p[15:11], p[15:13]};
        c.g = {p[10:5],  p[10:9]};
        c.b = {p[4:0],   p[4:2]};
        return c;
    endfunction

    function automatic rgb_t split_888(logic [23:0] p);
        rgb_t c;
        c.r = p[23:16];
        c.g = p[15:8];
        c.b = p[7:0];
        return c;
    endfunction

    // Place a full-depth colour on the selected panel bus, right-aligned
    function automatic logic [BUS_W-1:0] place_on_bus(bus_e w, rgb_t c);
        logic [BUS_W-1:0] o;
        case (w)
            BUS_24:  o = {c.r, c.g, c.b};
            BUS_18:  o = {6'd0, c.r[7:2], c.g[7:2], c.b[7:2]};
            BUS_16:  o = {8'd0, c.r[7:3], c.g[7:2], c.b[7:3]};
            default: o = '0;
        endcase
        return o;
    endfunction

endpackage

// File: rtl/lpu_cfg_check.sv
module lpu_cfg_check
    import lpu_pkg::*;
(
    input  logic [1:0] fmt_raw,
    input  logic [1:0] bus_raw,
    output fmt_e       fmt,
    output bus_e       bus,
    output logic       cfg_ok
);
    logic fmt_legal;
    logic bus_legal;

    assign fmt = fmt_e'(fmt_raw);
    assign bus = bus_e'(bus_raw);

    assign fmt_legal = (fmt == FMT_RGB565) || (fmt == FMT_RGB888);
    assign bus_legal = (bus != BUS_8);
    assign cfg_ok    = fmt_legal && bus_legal;
endmodule

// File: rtl/lpu_word_slicer.sv
module lpu_word_slicer
    import lpu_pkg::*;
#(
    parameter int WW = WORD_W,
    localparam int NL = WW / 8,
    localparam int HW = WW / 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_ok,
    input  fmt_e          fmt,
    input  logic          pix_strobe,
    input  logic          word_valid,
    input  logic [WW-1:0] word_data,
    output logic          word_ready,
    output logic          take,
    output logic          starve,
    output rgb_t          pix_rgb
);
    logic [NL-1:0] mask;
    logic [WW-1:0] masked;
    logic [HW-1:0] half_word;
    logic          upper_half;
    logic          last_pixel;

    assign mask = lane_mask(fmt);

    generate
        for (genvar i = 0; i < NL; i++) begin : g_lane
            assign masked[8*i +: 8] = word_data[8*i +: 8] & {8{mask[i]}};
        end
    endgenerate

    assign half_word = upper_half ? masked[WW-1:HW] : masked[HW-1:0];
    assign pix_rgb   = (fmt == FMT_RGB565) ? widen_565(half_word)
                                           : split_888(masked[23:0]);

    assign take       = pix_strobe && cfg_ok && word_valid;
    assign starve     = pix_strobe && cfg_ok && !word_valid;
    assign last_pixel = (fmt == FMT_RGB888) || upper_half;
    assign word_ready = take && last_pixel;

    always_ff @(posedge clk) begin
        if (rst || !cfg_ok || fmt != FMT_RGB565) begin
            upper_half <= 1'b0;
        end else if (take) begin
            upper_half <= ~upper_half;
        end
    end

    // R2
    ready_alternates_chk: assert property (@(posedge clk) disable iff (rst)
        (word_ready && fmt == FMT_RGB565 && $stable(fmt)) |-> !$past(word_ready));

    // R9
    starve_holds_pos_chk: assert property (@(posedge clk) disable iff (rst)
        (starve && $stable(fmt)) |=> $stable(upper_half));
endmodule

// File: rtl/lpu_bus_stage.sv
module lpu_bus_stage
    import lpu_pkg::*;
#(
    parameter int BW = BUS_W
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_e          bus,
    input  logic          take,
    input  logic          starve,
    input  rgb_t          pix_rgb,
    output logic          pix_valid,
    output logic [BW-1:0] pix_data,
    output logic          underflow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pix_valid <= 1'b0;
            pix_data  <= '0;
            underflow <= 1'b0;
        end else begin
            pix_valid <= take;
            pix_data  <= take ? place_on_bus(bus, pix_rgb) : '0;
            if (starve) begin
                underflow <= 1'b1;
            end
        end
    end

    // R9
    underflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

    // R9
    starve_blank_chk: assert property (@(posedge clk) disable iff (rst)
        starve |=> (!pix_valid && pix_data == '0 && underflow));

    // R6
    bus18_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take && bus == BUS_18) |=> (pix_data[BW-1:18] == '0));

    // R7
    bus16_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (take && bus == BUS_16) |=> (pix_data[BW-1:16] == '0));
endmodule

// File: rtl/lcd_pixel_unpacker.sv
module lcd_pixel_unpacker
    import lpu_pkg::*;
#(
    parameter int WORD_BITS = WORD_W,
    parameter int PIX_BITS  = BUS_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           cfg_word_fmt,
    input  logic [1:0]           cfg_bus_width,
    input  logic                 word_valid,
    input  logic [WORD_BITS-1:0] word_data,
    output logic                 word_ready,
    input  logic                 pix_strobe,
    output logic                 pix_valid,
    output logic [PIX_BITS-1:0]  pix_data,
    output logic                 cfg_err,
    output logic                 underflow
);
    fmt_e fmt;
    bus_e bus;
    logic cfg_ok;
    logic take;
    logic starve;
    rgb_t pix_rgb;

    lpu_cfg_check u_cfg (
        .fmt_raw (cfg_word_fmt),
        .bus_raw (cfg_bus_width),
        .fmt     (fmt),
        .bus     (bus),
        .cfg_ok  (cfg_ok)
    );

    lpu_word_slicer #(.WW(WORD_BITS)) u_slice (
        .clk        (clk),
        .rst        (rst),
        .cfg_ok     (cfg_ok),
        .fmt        (fmt),
        .pix_strobe (pix_strobe),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_ready (word_ready),
        .take       (take),
        .starve     (starve),
        .pix_rgb    (pix_rgb)
    );

    lpu_bus_stage #(.BW(PIX_BITS)) u_bus (
        .clk       (clk),
        .rst       (rst),
        .bus       (bus),
        .take      (take),
        .starve    (starve),
        .pix_rgb   (pix_rgb),
        .pix_valid (pix_valid),
        .pix_data  (pix_data),
        .underflow (underflow)
    );

    assign cfg_err = !cfg_ok;

    // R8
    err_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_err && $past(cfg_err)) |-> (!pix_valid && pix_data == '0 && !word_ready));

    // R10
    valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> $past(pix_strobe));
endmodule

// File: tb/lcd_pixel_unpacker_bench.sv
`timescale 1ns/1ps
module lcd_pixel_unpacker_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_word_fmt = 2'd0;
    logic [1:0]  cfg_bus_width = 2'd3;
    logic        word_valid = 1'b0;
    logic [31:0] word_data = '0;
    logic        word_ready;
    logic        pix_strobe = 1'b0;
    logic        pix_valid;
    logic [23:0] pix_data;
    logic        cfg_err;
    logic        underflow;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    lcd_pixel_unpacker u_lcd_pixel_unpacker (
        .clk           (clk),
        .rst           (rst),
        .cfg_word_fmt  (cfg_word_fmt),
        .cfg_bus_width (cfg_bus_width),
        .word_valid    (word_valid),
        .word_data     (word_data),
        .word_ready    (word_ready),
        .pix_strobe    (pix_strobe),
        .pix_valid     (pix_valid),
        .pix_data      (pix_data),
        .cfg_err       (cfg_err),
        .underflow     (underflow)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected bus value, derived from R4..R7
    function automatic logic [23:0] model(input logic [1:0] f, input logic [1:0] b,
                                          input logic [31:0] w, input logic hi);
        logic [7:0] r, g, bl;
        logic [15:0] p;
        if (f == 2'd0) begin
            p  = hi ? w[31:16] : w[15:0];
            r  = {p[15:11], p[15:13]};
            g  = {p[10:5], p[10:9]};
            bl = {p[4:0], p[4:2]};
        end else begin
            r  = w[23:16];
            g  = w[15:8];
            bl = w[7:0];
        end
        case (b)
            2'd3:    return {r, g, bl};
            2'd2:    return {6'd0, r[7:2], g[7:2], bl[7:2]};
            2'd0:    return {8'd0, r[7:3], g[7:2], bl[7:3]};
            default: return 24'd0;
        endcase
    endfunction

    task automatic do_reset(input logic [1:0] f, input logic [1:0] b);
        @(negedge clk);
        rst = 1'b1; pix_strobe = 1'b0; word_valid = 1'b0; word_data = '0;
        cfg_word_fmt = f; cfg_bus_width = b;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic s, input logic v, input logic [31:0] d, output logic rdy);
        @(negedge clk);
        pix_strobe = s; word_valid = v; word_data = d;
        #1 rdy = word_ready;
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic rdy;
        @(negedge clk);
        rst = 1'b1; cfg_word_fmt = 2'd0; cfg_bus_width = 2'd3;
        @(posedge clk); #1;
        check("R1 pix_valid", {31'd0, pix_valid}, 32'd0);
        check("R1 pix_data", {8'd0, pix_data}, 32'd0);
        check("R1 underflow", {31'd0, underflow}, 32'd0);
        check("R1 cfg_err", {31'd0, cfg_err}, 32'd0);
        @(negedge clk); rst = 1'b0;
        step(1'b0, 1'b1, 32'hFFFF_FFFF, rdy);
        check("R1 ready idle", {31'd0, rdy}, 32'd0);
        check("R1 valid after", {31'd0, pix_valid}, 32'd0);
    endtask

    task automatic t_packed_order(input logic [1:0] b, input logic [31:0] w);
        logic rdy;
        do_reset(2'd0, b);
        step(1'b1, 1'b1, w, rdy);
        check("R2 ready first half", {31'd0, rdy}, 32'd0);
        check("R2 valid first", {31'd0, pix_valid}, 32'd1);
        check("R2 low half first", {8'd0, pix_data}, {8'd0, model(2'd0, b, w, 1'b0)});
        step(1'b1, 1'b1, w, rdy);
        check("R2 ready second half", {31'd0, rdy}, 32'd1);
        check("R2 high half second", {8'd0, pix_data}, {8'd0, model(2'd0, b, w, 1'b1)});
    endtask

    task automatic t_unpacked(input logic [1:0] b, input logic [31:0] w);
        logic rdy;
        do_reset(2'd3, b);
        step(1'b1, 1'b1, w, rdy);
        check("R3 ready each pixel", {31'd0, rdy}, 32'd1);
        check("R3 pixel", {8'd0, pix_data}, {8'd0, model(2'd3, b, w, 1'b0)});
        step(1'b1, 1'b1, {~w[31:24], w[23:0]}, rdy);
        check("R3 top byte ignored", {8'd0, pix_data}, {8'd0, model(2'd3, b, w, 1'b0)});
    endtask

    task automatic t_widths;
        logic rdy;
        // R5: 5-6-5 green-only and magenta on 24-bit bus
        do_reset(2'd0, 2'd3);
        step(1'b1, 1'b1, 32'hF81F_07E0, rdy);
        check("R5 green widened", {8'd0, pix_data}, 32'h0000_FF00);
        step(1'b1, 1'b1, 32'hF81F_07E0, rdy);
        check("R5 magenta widened", {8'd0, pix_data}, 32'h00FF_00FF);
        // R6: 24-bit pixel truncated onto 18-bit bus
        do_reset(2'd3, 2'd2);
        step(1'b1, 1'b1, 32'h00FC_8404, rdy);
        check("R6 18-bit truncation", {8'd0, pix_data}, 32'h0003_F841);
        // R7: 24-bit pixel on 16-bit bus
        do_reset(2'd3, 2'd0);
        step(1'b1, 1'b1, 32'h00FF_0408, rdy);
        check("R7 16-bit truncation", {8'd0, pix_data}, 32'h0000_F821);
    endtask

    task automatic t_cfg_err(input logic [1:0] f, input logic [1:0] b);
        logic rdy;
        do_reset(f, b);
        step(1'b1, 1'b1, 32'h1234_5678, rdy);
        check("R8 cfg_err", {31'd0, cfg_err}, 32'd1);
        check("R8 no ready", {31'd0, rdy}, 32'd0);
        check("R8 no pixel", {7'd0, pix_valid, pix_data}, 32'd0);
        check("R8 no underflow", {31'd0, underflow}, 32'd0);
    endtask

    task automatic t_underflow;
        logic rdy;
        logic [31:0] w = 32'hABCD_1357;
        do_reset(2'd0, 2'd3);
        step(1'b1, 1'b1, w, rdy);
        step(1'b1, 1'b0, 32'd0, rdy);
        check("R9 underflow set", {31'd0, underflow}, 32'd1);
        check("R9 zero output", {7'd0, pix_valid, pix_data}, 32'd0);
        step(1'b1, 1'b1, w, rdy);
        check("R9 position held", {8'd0, pix_data}, {8'd0, model(2'd0, 2'd3, w, 1'b1)});
        check("R9 ready after gap", {31'd0, rdy}, 32'd1);
        step(1'b0, 1'b0, 32'd0, rdy);
        step(1'b0, 1'b0, 32'd0, rdy);
        check("R9 sticky", {31'd0, underflow}, 32'd1);
    endtask

    task automatic t_no_strobe;
        logic rdy;
        logic [31:0] w = 32'h5A5A_C3C3;
        do_reset(2'd0, 2'd2);
        step(1'b0, 1'b1, w, rdy);
        check("R10 no ready", {31'd0, rdy}, 32'd0);
        check("R10 idle output", {7'd0, pix_valid, pix_data}, 32'd0);
        step(1'b1, 1'b1, w, rdy);
        check("R10 low half still first", {8'd0, pix_data}, {8'd0, model(2'd0, 2'd2, w, 1'b0)});
        check("R10 valid", {31'd0, pix_valid}, 32'd1);
        check("R10 no underflow", {31'd0, underflow}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        t_reset();
        t_packed_order(2'd3, 32'hF81F_07E0);
        t_packed_order(2'd2, 32'h1234_ABCD);
        t_packed_order(2'd0, 32'h8421_7BEF);
        t_unpacked(2'd3, 32'hA512_3456);
        t_unpacked(2'd2, 32'h00FC_8404);
        t_unpacked(2'd0, 32'h7F80_41C3);
        t_widths();
        t_cfg_err(2'd3, 2'd1);
        t_cfg_err(2'd0, 2'd1);
        t_cfg_err(2'd1, 2'd3);
        t_cfg_err(2'd2, 2'd0);
        t_underflow();
        t_no_strobe();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule